// File: doc/BRIEF.md
# USB Link Status LED Controller

This block turns decoded status events from a USB device controller into a timed pattern on a single status LED. It is given single-cycle pulses for enumeration activity, for the device address being assigned or withdrawn, for a packet completed with an ACK handshake, and for a bus reset. It is also given a level input that is high while the device is suspended. It drives one registered LED output. Together, the LED pattern tells the link state at a glance.

Before an address exists, each enumeration event lights the LED for a short blink. Once the device is addressed, the LED stays lit. Every acknowledged transfer then blanks it for a fixed 100 ms. Suspend holds the LED dark. A bus reset or a withdrawn address returns the block to its dark, unconfigured state.

One parameter gives the number of clock cycles in 100 ms, so a simulation can use a short value. A second parameter divides that count to give the length of the enumeration blink. The block does no USB protocol decoding and does not drive the LED pad.

Top module: `usb_link_led`

## Requirements
- R1: A synchronous active-high `rst` drives `led` low at the next clock edge and forgets any address. After reset, `led` stays low while no event arrives.
- R2: While unaddressed, an `enum_evt` pulse lights `led` from the next edge for exactly TICKS_100MS/BLINK_DIV cycles, after which it goes dark. A new `enum_evt` during a blink restarts the full blink length.
- R3: An `addr_set` pulse (state ADDR_ON) lights `led` from the next edge. The LED stays lit for as long as no other event arrives.
- R4: While addressed, an `ack_evt` pulse (state ACK_OFF) drives `led` low from the next edge for exactly TICKS_100MS cycles, after which it returns high.
- R5: An `ack_evt` that arrives during a running off-pulse restarts the full TICKS_100MS off time. It is not queued.
- R6: `ack_evt` has no effect on `led` while no address is set.
- R7: `enum_evt` has no effect on `led` while an address is set. The LED stays lit.
- R8: While `suspend` is high (state SUSPEND), `led` is low from the next edge whatever other events arrive. Address set and clear events still update the remembered address.
- R9: After `suspend` falls, `led` is high if an address is still set and low otherwise. Any off-pulse or blink that was running is cancelled.
- R10: `bus_rst` or `addr_clr` (state UNCONF) drives `led` low from the next edge and clears the address. Only a later `enum_evt` or `addr_set` lights it again.
- R11: When events coincide in one cycle, the following order applies. `rst` wins over everything. `suspend` wins over the events. `bus_rst`/`addr_clr` win over `addr_set`. An `ack_evt` in the same cycle as `addr_set` starts an off-pulse.

States and transitions: UNCONF → ENUM_BLINK on `enum_evt`; ENUM_BLINK → UNCONF when the blink timer expires; UNCONF/ENUM_BLINK → ADDR_ON on `addr_set`; ADDR_ON → ACK_OFF on `ack_evt`; ACK_OFF → ADDR_ON when the pulse timer expires; any state → SUSPEND on `suspend`; SUSPEND → ADDR_ON or UNCONF when `suspend` falls; any state → UNCONF on `bus_rst`/`addr_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enum_evt | input | 1 | Single-cycle pulse: enumeration activity |
| addr_set | input | 1 | Single-cycle pulse: device address assigned |
| addr_clr | input | 1 | Single-cycle pulse: device address withdrawn |
| ack_evt | input | 1 | Single-cycle pulse: packet completed with ACK |
| bus_rst | input | 1 | Single-cycle pulse: USB bus reset seen |
| suspend | input | 1 | Level, high while the device is suspended |
| led | output | 1 | Registered LED drive, high = lit |

## Verification
The functions most likely to coincide are the acknowledge off-pulse and the address/suspend bookkeeping. An `ack_evt` can land in the same cycle as `addr_set`, `suspend`, `bus_rst` or a pulse that is expiring. Directed steps drive `addr_set` together with `ack_evt`, `bus_rst` together with `addr_set`, and `suspend` together with `ack_evt`. A long constrained-random run then overlaps all the events freely. Each cycle's `led` is judged against a bench model that holds the remaining on and off counts and applies the priority order of R11.

// File: rtl/usb_link_led_pkg.sv
package usb_link_led_pkg;

    typedef enum logic [2:0] {
        LS_UNCONF     = 3'd0,
        LS_ENUM_BLINK = 3'd1,
        LS_ADDR_ON    = 3'd2,
        LS_ACK_OFF    = 3'd3,
        LS_SUSPEND    = 3'd4
    } led_state_e;

    // LED is lit only in the blink and steady-on states
    function automatic logic state_lit(input led_state_e s);
        return (s == LS_ENUM_BLINK) || (s == LS_ADDR_ON);
    endfunction

endpackage

// File: rtl/usb_link_led_addr.sv
// Remembers whether the device currently holds an address.
module usb_link_led_addr (
    input  logic clk,
    input  logic rst,
    input  logic addr_set,
    input  logic drop,
    output logic addr_q,
    output logic addr_n
);

    always_comb begin
        if (drop)
            addr_n = 1'b0;
        else if (addr_set)
            addr_n = 1'b1;
        else
            addr_n = addr_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= 1'b0;
        else
            addr_q <= addr_n;
    end

endmodule

// File: rtl/usb_link_led_timer.sv
// Shared down-counter for blink and off-pulse intervals.
module usb_link_led_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/usb_link_led_fsm.sv
// Link-state machine and registered LED output.
module usb_link_led_fsm
    import usb_link_led_pkg::*;
#(
    parameter int W         = 8,
    parameter int PULSE_LEN = 20,
    parameter int BLINK_LEN = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         suspend,
    input  logic         drop,
    input  logic         enum_evt,
    input  logic         ack_evt,
    input  logic         addr_n,
    input  logic         tmr_done,
    output logic         tmr_load,
    output logic [W-1:0] tmr_val,
    output led_state_e   state_q,
    output logic         led
);

    localparam logic [W-1:0] PULSE_LD = W'(PULSE_LEN - 1);
    localparam logic [W-1:0] BLINK_LD = W'(BLINK_LEN - 1);

    led_state_e state_n;
    logic       hold;

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= LS_UNCONF;
        else
            state_q <= state_n;
    end

    // whether a timed state may continue
    always_comb begin
        unique case (state_q)
            LS_ACK_OFF:    hold = addr_n && !tmr_done;
            LS_ENUM_BLINK: hold = !addr_n && !tmr_done;
            LS_UNCONF,
            LS_ADDR_ON,
            LS_SUSPEND:    hold = 1'b0;
            default:       hold = 1'b0;
        endcase
    end

    // next state and timer load
    always_comb begin
        state_n  = state_q;
        tmr_load = 1'b0;
        tmr_val  = PULSE_LD;
        if (suspend) begin
            state_n = LS_SUSPEND;
        end else if (drop) begin
            state_n = LS_UNCONF;
        end else if (addr_n) begin
            if (ack_evt) begin
                state_n  = LS_ACK_OFF;
                tmr_load = 1'b1;
                tmr_val  = PULSE_LD;
            end else if (hold && state_q == LS_ACK_OFF) begin
                state_n = LS_ACK_OFF;
            end else begin
                state_n = LS_ADDR_ON;
            end
        end else begin
            if (enum_evt) begin
                state_n  = LS_ENUM_BLINK;
                tmr_load = 1'b1;
                tmr_val  = BLINK_LD;
            end else if (hold && state_q == LS_ENUM_BLINK) begin
                state_n = LS_ENUM_BLINK;
            end else begin
                state_n = LS_UNCONF;
            end
        end
    end

    // registered LED output
    always_ff @(posedge clk) begin
        if (rst)
            led <= 1'b0;
        else
            led <= state_lit(state_n);
    end

endmodule

// File: rtl/usb_link_led.sv
module usb_link_led
    import usb_link_led_pkg::*;
#(
    parameter int TICKS_100MS = 20_000_000,
    parameter int BLINK_DIV   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic enum_evt,
    input  logic addr_set,
    input  logic addr_clr,
    input  logic ack_evt,
    input  logic bus_rst,
    input  logic suspend,
    output logic led
);

    localparam int PULSE_LEN = (TICKS_100MS < 1) ? 1 : TICKS_100MS;
    localparam int BLINK_RAW = PULSE_LEN / ((BLINK_DIV < 1) ? 1 : BLINK_DIV);
    localparam int BLINK_LEN = (BLINK_RAW < 1) ? 1 : BLINK_RAW;
    localparam int CW        = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

    logic          drop;
    logic          addr_q;
    logic          addr_n;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    led_state_e    state_q;

    assign drop = bus_rst | addr_clr;

    usb_link_led_addr u_addr (
        .clk      (clk),
        .rst      (rst),
        .addr_set (addr_set),
        .drop     (drop),
        .addr_q   (addr_q),
        .addr_n   (addr_n)
    );

    usb_link_led_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    usb_link_led_fsm #(
        .W         (CW),
        .PULSE_LEN (PULSE_LEN),
        .BLINK_LEN (BLINK_LEN)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .suspend  (suspend),
        .drop     (drop),
        .enum_evt (enum_evt),
        .ack_evt  (ack_evt),
        .addr_n   (addr_n),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .state_q  (state_q),
        .led      (led)
    );

endmodule

// File: rtl/usb_link_led_chk.sv
module usb_link_led_chk (
    input logic clk,
    input logic rst,
    input logic enum_evt,
    input logic addr_set,
    input logic addr_clr,
    input logic ack_evt,
    input logic bus_rst,
    input logic suspend,
    input logic addr_q,
    input logic led
);

    logic quiet;
    assign quiet = !enum_evt && !addr_set && !addr_clr && !ack_evt && !bus_rst && !suspend;

    AST_RESET_DARK: assert property (@(posedge clk) rst |=> !led); // R1

    AST_ENUM_LIGHTS: assert property (@(posedge clk) disable iff (rst)
        (enum_evt && !addr_q && !addr_set && !addr_clr && !bus_rst && !suspend) |=> led); // R2

    AST_STEADY_ON: assert property (@(posedge clk) disable iff (rst)
        (led && addr_q && quiet) |=> led); // R3

    AST_ACK_DARK: assert property (@(posedge clk) disable iff (rst)
        (ack_evt && (addr_q || addr_set) && !addr_clr && !bus_rst && !suspend) |=> !led); // R4

    AST_SUSPEND_DARK: assert property (@(posedge clk) disable iff (rst)
        suspend |=> !led); // R8

    AST_RESUME_ON: assert property (@(posedge clk) disable iff (rst)
        ($past(suspend) && addr_q && quiet) |=> led); // R9

    AST_DROP_DARK: assert property (@(posedge clk) disable iff (rst)
        (bus_rst || addr_clr) |=> !led); // R10

    AST_DROP_BEATS_SET: assert property (@(posedge clk) disable iff (rst)
        (bus_rst && addr_set) |=> !addr_q); // R11

endmodule

bind usb_link_led usb_link_led_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .enum_evt (enum_evt),
    .addr_set (addr_set),
    .addr_clr (addr_clr),
    .ack_evt  (ack_evt),
    .bus_rst  (bus_rst),
    .suspend  (suspend),
    .addr_q   (addr_q),
    .led      (led)
);

// File: tb/usb_link_led_test.sv
`timescale 1ns/1ps
module usb_link_led_test;

    localparam int T = 20;      // cycles per 100 ms in simulation
    localparam int D = 4;
    localparam int B = T / D;   // blink length

    // stimulus bit positions
    localparam int B_ENUM = 0, B_ASET = 1, B_ACLR = 2, B_ACK = 3, B_BRST = 4, B_SUSP = 5, B_RST = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enum_evt = 0, addr_set = 0, addr_clr = 0, ack_evt = 0, bus_rst = 0, suspend = 0;
    logic led;

    int total = 0;
    int bad   = 0;

    // bench model
    bit m_addr = 0;
    bit m_led  = 0;
    int off_left = 0;
    int on_left  = 0;

    always #2.5 clk = ~clk;

    usb_link_led #(.TICKS_100MS(T), .BLINK_DIV(D)) uut (
        .clk(clk), .rst(rst), .enum_evt(enum_evt), .addr_set(addr_set),
        .addr_clr(addr_clr), .ack_evt(ack_evt), .bus_rst(bus_rst),
        .suspend(suspend), .led(led)
    );

    task automatic model(input logic [6:0] v);
        if (v[B_RST]) begin
            m_addr = 0; m_led = 0; off_left = 0; on_left = 0;
            return;
        end
        if (v[B_BRST] || v[B_ACLR]) m_addr = 0;
        else if (v[B_ASET])         m_addr = 1;
        if (v[B_SUSP]) begin
            m_led = 0; off_left = 0; on_left = 0;
        end else if (v[B_BRST] || v[B_ACLR]) begin
            m_led = 0; off_left = 0; on_left = 0;
        end else if (m_addr) begin
            on_left = 0;
            if (v[B_ACK]) begin
                off_left = T - 1; m_led = 0;
            end else if (off_left > 0) begin
                off_left--; m_led = 0;
            end else begin
                m_led = 1;
            end
        end else begin
            off_left = 0;
            if (v[B_ENUM]) begin
                on_left = B - 1; m_led = 1;
            end else if (on_left > 0) begin
                on_left--; m_led = 1;
            end else begin
                m_led = 0;
            end
        end
    endtask

    // called just after a falling edge
    task automatic step(input logic [6:0] v, input string tag);
        rst      = v[B_RST];
        enum_evt = v[B_ENUM];
        addr_set = v[B_ASET];
        addr_clr = v[B_ACLR];
        ack_evt  = v[B_ACK];
        bus_rst  = v[B_BRST];
        suspend  = v[B_SUSP];
        @(posedge clk);
        model(v);
        @(negedge clk);
        total++;
        if (led !== m_led) begin
            bad++;
            $display("FAIL %s: led=%0b expected=%0b at %0t", tag, led, m_led, $time);
        end
    endtask

    task automatic idle(input int n, input logic susp, input string tag);
        for (int i = 0; i < n; i++) step({1'b0, susp, 5'b0}, tag);
    endtask

    function automatic logic [6:0] ev(input int pos, input logic susp);
        logic [6:0] r = '0;
        r[pos]    = 1'b1;
        r[B_SUSP] = r[B_SUSP] | susp;
        return r;
    endfunction

    initial begin : watchdog
        repeat (100_000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [6:0] v;
        bit susp_lvl;
        void'($urandom(32'd1161));
        @(negedge clk);
        // R1: reset and quiet start
        step(7'b1 << B_RST, "R1");
        step(7'b1 << B_RST, "R1");
        idle(3, 0, "R1");
        // R2: blink and restart
        step(ev(B_ENUM, 0), "R2");
        idle(B + 2, 0, "R2");
        step(ev(B_ENUM, 0), "R2");
        idle(2, 0, "R2");
        step(ev(B_ENUM, 0), "R2");
        idle(B + 2, 0, "R2");
        // R6: ack before address
        step(ev(B_ACK, 0), "R6");
        idle(3, 0, "R6");
        step(ev(B_ENUM, 0), "R6");
        step(ev(B_ACK, 0), "R6");
        idle(B, 0, "R6");
        // R3: steady on
        step(ev(B_ASET, 0), "R3");
        idle(8, 0, "R3");
        // R7: enumeration ignored once addressed
        step(ev(B_ENUM, 0), "R7");
        idle(3, 0, "R7");
        // R4: off-pulse length
        step(ev(B_ACK, 0), "R4");
        idle(T + 3, 0, "R4");
        // R5: retrigger
        step(ev(B_ACK, 0), "R5");
        idle(10, 0, "R5");
        step(ev(B_ACK, 0), "R5");
        idle(T + 3, 0, "R5");
        // R8: suspend holds dark, R9: resume cancels pulse
        step(ev(B_ACK, 0), "R8");
        idle(3, 0, "R8");
        step(ev(B_SUSP, 1), "R8");
        step(ev(B_ACK, 1), "R8");
        step(ev(B_ENUM, 1), "R8");
        idle(3, 1, "R8");
        idle(4, 0, "R9");
        step(ev(B_SUSP, 1), "R9");
        step(ev(B_ACLR, 1), "R9");
        idle(2, 1, "R9");
        idle(4, 0, "R9");
        // R10: bus reset during blink and steady on
        step(ev(B_ENUM, 0), "R10");
        idle(1, 0, "R10");
        step(ev(B_BRST, 0), "R10");
        idle(3, 0, "R10");
        step(ev(B_ASET, 0), "R10");
        idle(2, 0, "R10");
        step(ev(B_ACLR, 0), "R10");
        idle(3, 0, "R10");
        step(ev(B_ENUM, 0), "R10");
        idle(B + 1, 0, "R10");
        // R11: coinciding events
        step(ev(B_ASET, 0) | ev(B_ACK, 0), "R11");
        idle(T + 2, 0, "R11");
        step(ev(B_BRST, 0) | ev(B_ASET, 0), "R11");
        idle(3, 0, "R11");
        step(ev(B_ASET, 0) | ev(B_SUSP, 1) | ev(B_ACK, 0), "R11");
        idle(2, 0, "R11");
        step(ev(B_ACK, 0) | ev(B_RST, 0), "R11");
        idle(2, 0, "R11");
        // R11: random mix
        susp_lvl = 0;
        for (int i = 0; i < 4000; i++) begin
            v = '0;
            if ($urandom_range(99) == 0) susp_lvl = ~susp_lvl;
            v[B_SUSP] = susp_lvl;
            v[B_ENUM] = ($urandom_range(15) == 0);
            v[B_ASET] = ($urandom_range(39) == 0);
            v[B_ACLR] = ($urandom_range(199) == 0);
            v[B_ACK]  = ($urandom_range(11) == 0);
            v[B_BRST] = ($urandom_range(299) == 0);
            v[B_RST]  = ($urandom_range(999) == 0);
            step(v, "R11");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule